// File: doc/BRIEF.md
# Tag-Verified Block Read Controller

This controller serves 32-byte block reads from flash whose contents may be protected by a per-block 4-byte authentication tag. For a block in an authenticated region it pulls 36 bytes over a byte-serial flash port: 32 ciphertext bytes followed by the stored tag. It then sends the block index and all 32 ciphertext bytes to an external tag engine. When the engine's tag comes back it is compared with the stored one. Only on a match are the bytes passed through an external combinational decryptor and streamed to the host, one byte per beat.

A mismatch withholds the whole block and raises a sticky fault. The fault holds, and new requests are refused, until the fault-clear input is pulsed. Blocks in unprotected regions skip the tag step entirely: 32 bytes are fetched from a denser layout and returned unchanged.

The sequencer moves through seven named states:
- IDLE: accepts a request and goes to FETCH.
- FETCH: on the final byte, goes to TAG_REQ in authenticated mode or to RELEASE in bypass mode.
- TAG_REQ: goes to TAG_WAIT when the engine takes the request.
- TAG_WAIT: goes to COMPARE when the engine responds.
- COMPARE: goes to RELEASE on a match or to FAULT on a mismatch.
- RELEASE: goes back to IDLE after the last beat.
- FAULT: goes back to IDLE when the fault-clear input is pulsed.

Top module: `tvb_rd_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle and no fault is held. A request is taken when `req_valid` and `req_ready` are both high; that edge latches `req_blk` and `req_auth` (1 = authenticated).
- R2: An authenticated read issues exactly 36 flash byte reads at addresses `blk*36 + k`, for k = 0..35 in ascending order. Bytes 0..31 are ciphertext. Bytes 32..35 form the stored tag, with byte 32 in bits 7:0 up to byte 35 in bits 31:24.
- R3: After the fetch, exactly one tag request is issued. It carries `tag_req_blk = blk` and ciphertext byte k at `tag_req_data[8k+7:8k]`, and holds both stable while `tag_req_ready` is low.
- R4: In authenticated mode no host beat appears before the engine's tag response has been received and compared.
- R5: On a tag match the host receives exactly 32 beats. Beat k equals the decryptor output for inputs (ciphertext byte k, index k, block). `rsp_last` is high on beat 31 only, and data and `rsp_last` are held while `rsp_ready` is low.
- R6: On a tag mismatch `fault` rises and no beat of that block is delivered.
- R7: `fault` stays high until `fault_clr` is pulsed. While it is high, requests are not accepted and no flash read starts. After the clear the controller is idle again.
- R8: A bypass read (`req_auth` = 0) issues exactly 32 flash reads at `blk*32 + k` and no tag request. It returns the raw bytes as 32 beats with `rsp_last` on beat 31.
- R9: Changing any single one of the 36 stored bytes of an authenticated block (ciphertext or tag) makes that read end in a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host read request valid |
| req_ready | output | 1 | Controller can take a request |
| req_blk | input | IDX_W | Block index to read |
| req_auth | input | 1 | 1 = authenticated region, 0 = bypass |
| fl_req | output | 1 | Flash byte read request |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_ack | input | 1 | Flash returns `fl_data` this cycle |
| fl_data | input | 8 | Flash read byte |
| tag_req_valid | output | 1 | Tag engine request valid |
| tag_req_ready | input | 1 | Tag engine takes the request |
| tag_req_blk | output | IDX_W | Block index for the tag computation |
| tag_req_data | output | 8*BLK_BYTES | Ciphertext, byte k at bits 8k+7:8k |
| tag_rsp_valid | input | 1 | Engine tag valid (single-cycle) |
| tag_rsp_tag | input | 8*TAG_BYTES | Engine-computed tag |
| dec_ct | output | 8 | Ciphertext byte to the decryptor |
| dec_idx | output | log2(BLK_BYTES) | Byte index within the block |
| dec_blk | output | IDX_W | Block index to the decryptor |
| dec_pt | input | 8 | Decryptor output (combinational) |
| rsp_valid | output | 1 | Host response beat valid |
| rsp_ready | input | 1 | Host takes the beat |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final beat of the block |
| fault | output | 1 | Sticky tag-mismatch fault |
| fault_clr | input | 1 | Clears the fault |

## Verification
A wrong byte counter or buffer slot shows up as a flash address out of order, or as one misplaced byte in the tag request or the returned beats. This is visible within the same block. A wrong transition from COMPARE shows up either as beats from a corrupted block or as a fault on a clean block, within one read. A corruption sweep over every one of the 36 stored byte positions exposes any byte that is left out of the tag path or the stored-tag register.

// File: rtl/tvb_pkg.sv
package tvb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_TAG_REQ,
        ST_TAG_WAIT,
        ST_COMPARE,
        ST_RELEASE,
        ST_FAULT
    } tvb_state_e;
endpackage

// File: rtl/tvb_byte_store.sv
// Ciphertext buffer plus stored-tag register, filled by a byte index.
module tvb_byte_store #(
    parameter int BLK_BYTES = 32,
    parameter int TAG_BYTES = 4,
    parameter int CNT_W     = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [CNT_W-1:0]       wr_idx,
    input  logic [7:0]             wr_byte,
    input  logic [CNT_W-1:0]       rd_idx,
    output logic [7:0]             rd_byte,
    output logic [8*BLK_BYTES-1:0] ct_flat,
    output logic [8*TAG_BYTES-1:0] tag_flat
);
    // Fetch slots below BLK_BYTES hold ciphertext.
    for (genvar i = 0; i < BLK_BYTES; i++) begin : g_ct
        localparam logic [CNT_W-1:0] SLOT = CNT_W'(i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ct_flat[8*i +: 8] <= '0;
            else if (wr_en && wr_idx == SLOT)
                ct_flat[8*i +: 8] <= wr_byte;
        end
    end

    // Fetch slots from BLK_BYTES upward hold the stored tag.
    for (genvar j = 0; j < TAG_BYTES; j++) begin : g_tag
        localparam logic [CNT_W-1:0] SLOT = CNT_W'(BLK_BYTES + j);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                tag_flat[8*j +: 8] <= '0;
            else if (wr_en && wr_idx == SLOT)
                tag_flat[8*j +: 8] <= wr_byte;
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < BLK_BYTES; i++) begin
            if (rd_idx == CNT_W'(i))
                rd_byte = ct_flat[8*i +: 8];
        end
    end
endmodule

// File: rtl/tvb_tag_cmp.sv
// Captures the engine tag and compares it with the stored tag.
module tvb_tag_cmp #(
    parameter int TAG_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_en,
    input  logic [8*TAG_BYTES-1:0] eng_tag,
    input  logic [8*TAG_BYTES-1:0] stored_tag,
    output logic                   match
);
    logic [8*TAG_BYTES-1:0] eng_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            eng_q <= '0;
        else if (cap_en)
            eng_q <= eng_tag;
    end

    assign match = (eng_q == stored_tag);
endmodule

// File: rtl/tvb_seq.sv
// Read sequencer: state register, byte counter, mode latch, control outputs.
module tvb_seq
    import tvb_pkg::*;
#(
    parameter int BLK_BYTES = 32,
    parameter int TAG_BYTES = 4,
    parameter int CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_auth,
    input  logic             fl_ack,
    input  logic             tag_req_ready,
    input  logic             tag_rsp_valid,
    input  logic             tag_match,
    input  logic             rsp_ready,
    input  logic             fault_clr,
    output tvb_state_e       state,
    output logic [CNT_W-1:0] cnt,
    output logic             auth_q,
    output logic             req_ready,
    output logic             fl_req,
    output logic             store_en,
    output logic             tag_req_valid,
    output logic             tag_cap,
    output logic             rsp_valid,
    output logic             rsp_last,
    output logic             fault
);
    localparam int FULL = BLK_BYTES + TAG_BYTES;
    localparam logic [CNT_W-1:0] LAST_FULL = CNT_W'(FULL - 1);
    localparam logic [CNT_W-1:0] LAST_BLK  = CNT_W'(BLK_BYTES - 1);

    tvb_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             accept;
    logic             fetch_done;
    logic             rel_done;
    logic [CNT_W-1:0] fetch_last;

    assign fetch_last = auth_q ? LAST_FULL : LAST_BLK;
    assign accept     = (state_q == ST_IDLE) && req_valid;
    assign fetch_done = (state_q == ST_FETCH) && fl_ack && (cnt_q == fetch_last);
    assign rel_done   = (state_q == ST_RELEASE) && rsp_ready && (cnt_q == LAST_BLK);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Byte counter and mode latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            auth_q <= 1'b0;
        end else if (accept) begin
            cnt_q  <= '0;
            auth_q <= req_auth;
        end else if (state_q == ST_FETCH && fl_ack) begin
            cnt_q  <= fetch_done ? '0 : cnt_q + 1'b1;
        end else if (state_q == ST_RELEASE && rsp_ready) begin
            cnt_q  <= rel_done ? '0 : cnt_q + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_valid)     state_d = ST_FETCH;
            ST_FETCH:    if (fetch_done)    state_d = auth_q ? ST_TAG_REQ : ST_RELEASE;
            ST_TAG_REQ:  if (tag_req_ready) state_d = ST_TAG_WAIT;
            ST_TAG_WAIT: if (tag_rsp_valid) state_d = ST_COMPARE;
            ST_COMPARE:  state_d = tag_match ? ST_RELEASE : ST_FAULT;
            ST_RELEASE:  if (rel_done)      state_d = ST_IDLE;
            ST_FAULT:    if (fault_clr)     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Outputs per state
    always_comb begin
        req_ready     = 1'b0;
        fl_req        = 1'b0;
        store_en      = 1'b0;
        tag_req_valid = 1'b0;
        tag_cap       = 1'b0;
        rsp_valid     = 1'b0;
        rsp_last      = 1'b0;
        fault         = 1'b0;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_FETCH: begin
                fl_req   = 1'b1;
                store_en = fl_ack;
            end
            ST_TAG_REQ:  tag_req_valid = 1'b1;
            ST_TAG_WAIT: tag_cap = tag_rsp_valid;
            ST_COMPARE:  ;
            ST_RELEASE: begin
                rsp_valid = 1'b1;
                rsp_last  = (cnt_q == LAST_BLK);
            end
            ST_FAULT:    fault = 1'b1;
            default:     ;
        endcase
    end

    assign state = state_q;
    assign cnt   = cnt_q;
endmodule

// File: rtl/tvb_rd_ctrl.sv
// Top: tag-verified block read controller.
module tvb_rd_ctrl
    import tvb_pkg::*;
#(
    parameter int BLK_BYTES = 32,
    parameter int TAG_BYTES = 4,
    parameter int IDX_W     = 8,
    localparam int FULL     = BLK_BYTES + TAG_BYTES,
    localparam int CNT_W    = $clog2(FULL + 1),
    localparam int DI_W     = $clog2(BLK_BYTES),
    localparam int ADDR_W   = IDX_W + $clog2(FULL)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [IDX_W-1:0]       req_blk,
    input  logic                   req_auth,
    output logic                   fl_req,
    output logic [ADDR_W-1:0]      fl_addr,
    input  logic                   fl_ack,
    input  logic [7:0]             fl_data,
    output logic                   tag_req_valid,
    input  logic                   tag_req_ready,
    output logic [IDX_W-1:0]       tag_req_blk,
    output logic [8*BLK_BYTES-1:0] tag_req_data,
    input  logic                   tag_rsp_valid,
    input  logic [8*TAG_BYTES-1:0] tag_rsp_tag,
    output logic [7:0]             dec_ct,
    output logic [DI_W-1:0]        dec_idx,
    output logic [IDX_W-1:0]       dec_blk,
    input  logic [7:0]             dec_pt,
    output logic                   rsp_valid,
    input  logic                   rsp_ready,
    output logic [7:0]             rsp_data,
    output logic                   rsp_last,
    output logic                   fault,
    input  logic                   fault_clr
);
    tvb_state_e             st;
    logic [CNT_W-1:0]       cnt;
    logic                   auth_q;
    logic                   store_en;
    logic                   tag_cap;
    logic                   tag_match;
    logic [IDX_W-1:0]       blk_q;
    logic [7:0]             buf_byte;
    logic [8*TAG_BYTES-1:0] stored_tag;
    logic [ADDR_W-1:0]      stride;

    tvb_seq #(
        .BLK_BYTES(BLK_BYTES),
        .TAG_BYTES(TAG_BYTES),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_auth     (req_auth),
        .fl_ack       (fl_ack),
        .tag_req_ready(tag_req_ready),
        .tag_rsp_valid(tag_rsp_valid),
        .tag_match    (tag_match),
        .rsp_ready    (rsp_ready),
        .fault_clr    (fault_clr),
        .state        (st),
        .cnt          (cnt),
        .auth_q       (auth_q),
        .req_ready    (req_ready),
        .fl_req       (fl_req),
        .store_en     (store_en),
        .tag_req_valid(tag_req_valid),
        .tag_cap      (tag_cap),
        .rsp_valid    (rsp_valid),
        .rsp_last     (rsp_last),
        .fault        (fault)
    );

    tvb_byte_store #(
        .BLK_BYTES(BLK_BYTES),
        .TAG_BYTES(TAG_BYTES),
        .CNT_W    (CNT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_en),
        .wr_idx  (cnt),
        .wr_byte (fl_data),
        .rd_idx  (cnt),
        .rd_byte (buf_byte),
        .ct_flat (tag_req_data),
        .tag_flat(stored_tag)
    );

    tvb_tag_cmp #(
        .TAG_BYTES(TAG_BYTES)
    ) u_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (tag_cap),
        .eng_tag   (tag_rsp_tag),
        .stored_tag(stored_tag),
        .match     (tag_match)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            blk_q <= '0;
        else if (req_valid && req_ready)
            blk_q <= req_blk;
    end

    // Authenticated blocks are laid out with their tags; bypass blocks are dense.
    assign stride  = auth_q ? ADDR_W'(FULL) : ADDR_W'(BLK_BYTES);
    assign fl_addr = ADDR_W'(blk_q) * stride + ADDR_W'(cnt);

    assign tag_req_blk = blk_q;
    assign dec_ct      = buf_byte;
    assign dec_idx     = cnt[DI_W-1:0];
    assign dec_blk     = blk_q;
    assign rsp_data    = auth_q ? dec_pt : buf_byte;
endmodule

// File: rtl/tvb_chk.sv
// Protocol and safety checker bound to the top module.
module tvb_chk
    import tvb_pkg::*;
#(
    parameter int BLK_BYTES = 32,
    parameter int IDX_W     = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_ready,
    input logic                   fl_req,
    input logic                   tag_req_valid,
    input logic                   tag_req_ready,
    input logic [IDX_W-1:0]       tag_req_blk,
    input logic [8*BLK_BYTES-1:0] tag_req_data,
    input logic                   rsp_valid,
    input logic                   rsp_ready,
    input logic [7:0]             rsp_data,
    input logic                   rsp_last,
    input logic                   fault,
    input logic                   fault_clr,
    input logic                   auth_q,
    input tvb_state_e             st
);
    a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !fault && !rsp_valid && !fl_req && !tag_req_valid);

    a_r3_tag_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        tag_req_valid && !tag_req_ready |=> tag_req_valid && $stable(tag_req_data) && $stable(tag_req_blk));

    a_r4_release_after_compare: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) && auth_q |-> $past(st) == ST_COMPARE);

    a_r5_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_last));

    a_r6_no_data_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !rsp_valid);

    a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault && !fault_clr |=> fault);

    a_r7_refuse_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !req_ready && !fl_req);

    a_r8_bypass_no_tag: assert property (@(posedge clk) disable iff (!rst_n)
        tag_req_valid |-> auth_q);
endmodule

bind tvb_rd_ctrl tvb_chk #(
    .BLK_BYTES(BLK_BYTES),
    .IDX_W    (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .fl_req       (fl_req),
    .tag_req_valid(tag_req_valid),
    .tag_req_ready(tag_req_ready),
    .tag_req_blk  (tag_req_blk),
    .tag_req_data (tag_req_data),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_data     (rsp_data),
    .rsp_last     (rsp_last),
    .fault        (fault),
    .fault_clr    (fault_clr),
    .auth_q       (auth_q),
    .st           (st)
);

// File: tb/sim_tvb_rd_ctrl.sv
`timescale 1ns/1ps
module sim_tvb_rd_ctrl;
    localparam int BLK    = 32;
    localparam int TAG    = 4;
    localparam int IDX_W  = 8;
    localparam int FULL   = BLK + TAG;
    localparam int DI_W   = 5;
    localparam int ADDR_W = IDX_W + 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [IDX_W-1:0]  req_blk = '0;
    logic              req_auth = 1'b0;
    logic              fl_req;
    logic [ADDR_W-1:0] fl_addr;
    logic              fl_ack;
    logic [7:0]        fl_data;
    logic              tag_req_valid;
    logic              tag_req_ready;
    logic [IDX_W-1:0]  tag_req_blk;
    logic [8*BLK-1:0]  tag_req_data;
    logic              tag_rsp_valid = 1'b0;
    logic [8*TAG-1:0]  tag_rsp_tag = '0;
    logic [7:0]        dec_ct;
    logic [DI_W-1:0]   dec_idx;
    logic [IDX_W-1:0]  dec_blk;
    logic [7:0]        dec_pt;
    logic              rsp_valid;
    logic              rsp_ready;
    logic [7:0]        rsp_data;
    logic              rsp_last;
    logic              fault;
    logic              fault_clr = 1'b0;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // flash layout and corruption control
    logic        lay_auth = 1'b0;
    logic        cor_en = 1'b0;
    int          cor_addr = 0;
    logic        fl_go = 1'b0, tr_go = 1'b0, rr_go = 1'b0;

    always #5 clk = ~clk;

    tvb_rd_ctrl #(.BLK_BYTES(BLK), .TAG_BYTES(TAG), .IDX_W(IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_blk(req_blk), .req_auth(req_auth),
        .fl_req(fl_req), .fl_addr(fl_addr), .fl_ack(fl_ack), .fl_data(fl_data),
        .tag_req_valid(tag_req_valid), .tag_req_ready(tag_req_ready),
        .tag_req_blk(tag_req_blk), .tag_req_data(tag_req_data),
        .tag_rsp_valid(tag_rsp_valid), .tag_rsp_tag(tag_rsp_tag),
        .dec_ct(dec_ct), .dec_idx(dec_idx), .dec_blk(dec_blk), .dec_pt(dec_pt),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .fault(fault), .fault_clr(fault_clr)
    );

    function automatic logic [7:0] ct_byte(int b, int o);
        return 8'(b * 29 + o * 11 + 7) ^ 8'(o * o);
    endfunction

    function automatic logic [31:0] tag_of(int b, logic [8*BLK-1:0] d);
        logic [31:0] h = 32'h9E37_79B9 ^ 32'(b);
        for (int k = 0; k < BLK; k++)
            h = {h[26:0], h[31:27]} ^ {24'h0, d[8*k +: 8]} ^ 32'(k << 8);
        return h;
    endfunction

    function automatic logic [8*BLK-1:0] clean_blk(int b);
        logic [8*BLK-1:0] d;
        for (int k = 0; k < BLK; k++) d[8*k +: 8] = ct_byte(b, k);
        return d;
    endfunction

    function automatic logic [7:0] flash_byte(int a, logic la, logic ce, int ca);
        logic [7:0]  v;
        logic [31:0] t;
        int b, o;
        if (la) begin
            b = a / FULL; o = a % FULL;
            if (o < BLK) v = ct_byte(b, o);
            else begin
                t = tag_of(b, clean_blk(b));
                v = t[8*(o-BLK) +: 8];
            end
        end else begin
            b = a / BLK; o = a % BLK;
            v = ct_byte(b, o);
        end
        if (ce && a == ca) v = v ^ 8'h5A;
        return v;
    endfunction

    function automatic logic [7:0] dec_of(logic [7:0] c, int k, int b);
        return c ^ 8'(k * 13 + b);
    endfunction

    assign fl_data       = flash_byte(int'(fl_addr), lay_auth, cor_en, cor_addr);
    assign fl_ack        = fl_req & fl_go;
    assign tag_req_ready = tr_go;
    assign rsp_ready     = rr_go;
    assign dec_pt        = dec_of(dec_ct, int'(dec_idx), int'(dec_blk));

    // stall patterns
    always @(posedge clk) begin
        cyc   <= cyc + 1;
        fl_go <= (cyc % 5) != 2;
        tr_go <= (cyc % 3) != 0;
        rr_go <= (cyc % 4) != 1;
    end

    // behavioural tag engine, three cycles of latency
    int          te_cnt = 0;
    logic [31:0] te_tag = '0;
    always @(posedge clk) begin
        tag_rsp_valid <= 1'b0;
        if (!rst_n) te_cnt <= 0;
        else if (te_cnt != 0) begin
            te_cnt <= te_cnt - 1;
            if (te_cnt == 1) begin
                tag_rsp_valid <= 1'b1;
                tag_rsp_tag   <= te_tag;
            end
        end else if (tag_req_valid && tag_req_ready) begin
            te_cnt <= 3;
            te_tag <= tag_of(int'(tag_req_blk), tag_req_data);
        end
    end

    // monitors, sampled mid-cycle
    logic [ADDR_W-1:0] fl_log [64];
    logic [7:0]        bt_log [64];
    logic              bl_log [64];
    int n_fl = 0, n_tr = 0, n_bt = 0, n_rsp = 0, rsp_at_first = -1;
    logic [8*BLK-1:0]  tr_data;
    logic [IDX_W-1:0]  tr_blk;

    always @(negedge clk) begin
        if (fl_req && fl_ack) begin
            if (n_fl < 64) fl_log[n_fl] = fl_addr;
            n_fl++;
        end
        if (tag_req_valid && tag_req_ready) begin
            n_tr++;
            tr_data = tag_req_data;
            tr_blk  = tag_req_blk;
        end
        if (tag_rsp_valid) n_rsp++;
        if (rsp_valid && rsp_ready) begin
            if (n_bt == 0) rsp_at_first = n_rsp;
            if (n_bt < 64) begin
                bt_log[n_bt] = rsp_data;
                bl_log[n_bt] = rsp_last;
            end
            n_bt++;
        end
    end

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_read(int b, bit auth, int cor_off);
        int stride = auth ? FULL : BLK;
        int t = 0;
        int errs;
        logic [8*BLK-1:0] exp_d;
        @(negedge clk);
        lay_auth = auth;
        cor_en   = (cor_off >= 0);
        cor_addr = b * stride + cor_off;
        n_fl = 0; n_tr = 0; n_bt = 0; n_rsp = 0; rsp_at_first = -1;
        chk(req_ready == 1'b1, "R1", "ready when idle", req_ready, 1);
        req_valid = 1'b1; req_blk = IDX_W'(b); req_auth = auth;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R1", "ready low while busy", req_ready, 0);
        while (n_bt < BLK && !fault && t < 3000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);

        // flash read sequence
        errs = 0;
        for (int k = 0; k < stride && k < n_fl; k++)
            if (int'(fl_log[k]) != b * stride + k) errs++;
        chk(n_fl == stride && errs == 0, auth ? "R2" : "R8", "flash reads (count/bad addrs)",
            longint'(n_fl) * 256 + errs, stride * 256);

        if (auth) begin
            exp_d = clean_blk(b);
            if (cor_off >= 0 && cor_off < BLK) exp_d[8*cor_off +: 8] ^= 8'h5A;
            chk(n_tr == 1 && tr_blk == IDX_W'(b), "R3", "tag request count/blk", n_tr, 1);
            chk(tr_data == exp_d, "R3", "tag request data low word", tr_data[63:0], exp_d[63:0]);
        end else begin
            chk(n_tr == 0, "R8", "no tag request in bypass", n_tr, 0);
        end

        if (cor_off >= 0) begin
            chk(fault == 1'b1, "R9", "corrupted byte faults", fault, 1);
            chk(n_bt == 0, "R6", "no beats on mismatch", n_bt, 0);
            req_valid = 1'b1;
            repeat (4) begin
                @(negedge clk);
                chk(req_ready == 1'b0 && fault == 1'b1, "R7", "refuse while fault", req_ready, 0);
            end
            chk(n_fl == stride, "R7", "no flash read during fault", n_fl, stride);
            req_valid = 1'b0;
            fault_clr = 1'b1;
            @(negedge clk);
            fault_clr = 1'b0;
            chk(fault == 1'b0 && req_ready == 1'b1, "R7", "cleared to idle", {fault, req_ready}, 1);
        end else begin
            chk(fault == 1'b0, "R6", "no fault on clean block", fault, 0);
            chk(n_bt == BLK, auth ? "R5" : "R8", "beat count", n_bt, BLK);
            if (auth) chk(rsp_at_first == 1, "R4", "beats follow tag response", rsp_at_first, 1);
            errs = 0;
            for (int k = 0; k < BLK; k++) begin
                logic [7:0] e = auth ? dec_of(ct_byte(b, k), k, b) : ct_byte(b, k);
                if (bt_log[k] !== e || bl_log[k] !== (k == BLK - 1)) errs++;
            end
            chk(errs == 0, auth ? "R5" : "R8", "beat data/last mismatches", errs, 0);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 150000) begin
                bad++; total++;
                $display("FAIL watchdog: actual=%0d expected<150000", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && fl_req == 1'b0, "R1", "reset idle", req_ready, 1);
        chk(fault == 1'b0 && rsp_valid == 1'b0 && tag_req_valid == 1'b0, "R6", "reset quiet",
            {fault, rsp_valid, tag_req_valid}, 0);
        for (int b = 0; b < 16; b++) do_read(b, 1'b1, -1);
        do_read(255, 1'b1, -1);
        for (int b = 0; b < 16; b++) do_read(b, 1'b0, -1);
        do_read(255, 1'b0, -1);
        for (int o = 0; o < FULL; o++) do_read(7, 1'b1, o);
        do_read(200, 1'b1, 35);
        do_read(7, 1'b1, -1);
        do_read(9, 1'b0, -1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule